// File: doc/BRIEF.md
# Narrow-to-Wide Memory Command Packer

This block sits between a channel arbiter and the user interface of a wide memory controller. The controller moves 512-bit bursts of eight 64-bit beats. The arbiter hands over one 64-bit channel operation at a time, either a write or a read. The operation carries a 28-bit word address and a small channel tag.

For a write, the block aligns the address to a burst boundary and places the 64-bit word in one lane of the 512-bit data bus. The lane is selected by the three low address bits. A byte mask protects the other 56 bytes. The command, the data, the data write strobe and the data end strobe all go out in the same cycle.

For a read, the block sends the aligned address with a read command. When the controller accepts that command, the block pushes the channel tag and the lane offset into an in-order tracking queue. A separate return path drains this queue so it can pick the right 64 bits out of each returned burst.

Top module: `cpk_top`

## Requirements
- R1: Whenever a command is offered (`mem_en` high), `mem_addr` equals the held request address with its three least significant bits forced to zero.
- R2: A write is offered with command code 3'b000. `mem_en`, `mem_wdf_wren` and `mem_wdf_end` rise together, and only in a cycle where both `mem_cmd_rdy` and `mem_wdf_rdy` are high.
- R3: During a pending write, `mem_wdf_data[64*k +: 64]` carries the request word, where k = request address bits [2:0]. Every other lane is zero.
- R4: During a pending write, mask bit j covers data byte j (bits [8*j +: 8]). Mask bits are 0 for the 8 bytes of lane k and 1 for all 56 other bytes.
- R5: A read is offered with command code 3'b001. `mem_en` stays high from the cycle after acceptance until `mem_cmd_rdy` is seen high, whatever `mem_wdf_rdy` does. `mem_wdf_wren` and `mem_wdf_end` stay low.
- R6: A cycle with neither `req_wr` nor `req_rd` set accepts nothing, and no command follows from it.
- R7: A request is accepted in a cycle where `req_ready` is high and either enable is set. The command is offered from the next cycle. `req_ready` stays low until the memory interface has taken that command.
- R8: Each accepted read command pushes {tag, address bits [2:0]} into a first-in first-out tracking queue. `trk_valid`, `trk_tag` and `trk_off` show the oldest entry, and `trk_pop` removes it.
- R9: `req_ready` is low whenever the tracking queue holds TRK_DEPTH entries.
- R10: After reset, no command is offered, the tracking queue is empty and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write request from the arbiter |
| req_rd | input | 1 | Read request from the arbiter (never set together with req_wr) |
| req_tag | input | TAG_W (3) | Channel tag of the request |
| req_addr | input | ADDR_W (28) | 64-bit word address |
| req_wdata | input | NARROW_W (64) | Write word |
| req_ready | output | 1 | Block can take a request this cycle |
| mem_cmd_rdy | input | 1 | Controller accepts a command |
| mem_wdf_rdy | input | 1 | Controller accepts write data |
| mem_en | output | 1 | Command valid |
| mem_cmd | output | 3 | Command code: 000 write, 001 read |
| mem_addr | output | ADDR_W (28) | Burst-aligned address |
| mem_wdf_data | output | WIDE_W (512) | Wide write data |
| mem_wdf_mask | output | WIDE_W/8 (64) | Byte mask, 1 means byte not written |
| mem_wdf_wren | output | 1 | Write data valid |
| mem_wdf_end | output | 1 | Last beat of write data |
| trk_pop | input | 1 | Remove the oldest tracking entry |
| trk_valid | output | 1 | Tracking queue not empty |
| trk_tag | output | TAG_W (3) | Tag of the oldest read |
| trk_off | output | 3 | Lane offset of the oldest read |

## Verification
The bench keeps the 64-bit and 512-bit widths and the 28-bit address at their defaults, so every one of the eight lanes and every mask pattern is reached through random low address bits. It lowers TRK_DEPTH to 4. With that depth, a stretch of reads with the pop input held low fills the queue in a handful of cycles, which exercises the full-queue back-pressure and the pop-while-push ordering many times. The ready inputs are also withheld at random, so that held reads and writes that are waiting for data-ready are both covered.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  typedef enum logic [2:0] {
    OP_WRITE = 3'b000,
    OP_READ  = 3'b001
  } ui_op_e;
endpackage

// File: rtl/cpk_lane_packer.sv
module cpk_lane_packer #(
  parameter int NARROW_W = 64,
  parameter int WIDE_W   = 512,
  localparam int LANES   = WIDE_W / NARROW_W,
  localparam int OFF_W   = $clog2(LANES),
  localparam int LANE_B  = NARROW_W / 8,
  localparam int MASK_W  = WIDE_W / 8
) (
  input  logic [OFF_W-1:0]    lane,
  input  logic [NARROW_W-1:0] word,
  output logic [WIDE_W-1:0]   wide,
  output logic [MASK_W-1:0]   mask
);
  // one slice per lane: the selected lane takes the word and opens its bytes
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit;
    assign hit = (lane == OFF_W'(i));
    assign wide[i*NARROW_W +: NARROW_W] = hit ? word : '0;
    assign mask[i*LANE_B +: LANE_B]     = hit ? '0 : '1;
  end
endmodule

// File: rtl/cpk_track_fifo.sv
module cpk_track_fifo #(
  parameter int ENT_W = 6,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] push_data,
  input  logic             pop,
  output logic [ENT_W-1:0] head,
  output logic             not_empty,
  output logic             full
);
  logic [ENT_W-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             pop_eff;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign not_empty = (count != '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign pop_eff   = pop && not_empty;
  assign head      = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop_eff) rd_ptr <= step(rd_ptr);
      if (push && !pop_eff) count <= count + 1'b1;
      else if (!push && pop_eff) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R8
  first_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !not_empty) |=> (not_empty && head == $past(push_data)));
endmodule

// File: rtl/cpk_cmd_hold.sv
module cpk_cmd_hold #(
  parameter int ADDR_W   = 28,
  parameter int NARROW_W = 64,
  parameter int TAG_W    = 3,
  parameter int OFF_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                load_wr,
  input  logic [TAG_W-1:0]    load_tag,
  input  logic [ADDR_W-1:0]   load_addr,
  input  logic [NARROW_W-1:0] load_word,
  input  logic                cmd_rdy,
  input  logic                wdf_rdy,
  output logic                pending,
  output logic                hold_wr,
  output logic [TAG_W-1:0]    hold_tag,
  output logic [OFF_W-1:0]    hold_off,
  output logic [NARROW_W-1:0] hold_word,
  output logic [ADDR_W-1:0]   ui_addr,
  output logic                ui_en,
  output logic                ui_wren,
  output logic                rd_fire
);
  logic [ADDR_W-1:0] hold_addr;
  logic              wr_go;
  logic              fire;

  function automatic logic [ADDR_W-1:0] burst_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  assign ui_addr  = burst_base(hold_addr);
  assign hold_off = hold_addr[OFF_W-1:0];
  assign wr_go    = pending && hold_wr && cmd_rdy && wdf_rdy;
  assign ui_en    = hold_wr ? wr_go : pending;
  assign ui_wren  = wr_go;
  assign fire     = ui_en && cmd_rdy;
  assign rd_fire  = fire && !hold_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      hold_wr   <= 1'b0;
      hold_tag  <= '0;
      hold_addr <= '0;
      hold_word <= '0;
    end else if (load) begin
      pending   <= 1'b1;
      hold_wr   <= load_wr;
      hold_tag  <= load_tag;
      hold_addr <= load_addr;
      hold_word <= load_word;
    end else if (fire) begin
      pending   <= 1'b0;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !fire) |=> (pending && $stable(hold_addr) && $stable(hold_wr)));
  // R7
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !pending);
  // R5
  read_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !hold_wr && !cmd_rdy) |=> ui_en);
endmodule

// File: rtl/cpk_top.sv
module cpk_top #(
  parameter int ADDR_W    = 28,
  parameter int NARROW_W  = 64,
  parameter int WIDE_W    = 512,
  parameter int TAG_W     = 3,
  parameter int TRK_DEPTH = 16,
  localparam int LANES    = WIDE_W / NARROW_W,
  localparam int OFF_W    = $clog2(LANES),
  localparam int MASK_W   = WIDE_W / 8,
  localparam int LANE_B   = NARROW_W / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr,
  input  logic                req_rd,
  input  logic [TAG_W-1:0]    req_tag,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [NARROW_W-1:0] req_wdata,
  output logic                req_ready,
  input  logic                mem_cmd_rdy,
  input  logic                mem_wdf_rdy,
  output logic                mem_en,
  output logic [2:0]          mem_cmd,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WIDE_W-1:0]   mem_wdf_data,
  output logic [MASK_W-1:0]   mem_wdf_mask,
  output logic                mem_wdf_wren,
  output logic                mem_wdf_end,
  input  logic                trk_pop,
  output logic                trk_valid,
  output logic [TAG_W-1:0]    trk_tag,
  output logic [OFF_W-1:0]    trk_off
);
  import cpk_pkg::*;

  logic                pending, hold_wr, ui_en, ui_wren, rd_fire;
  logic                accept, trk_full;
  logic [TAG_W-1:0]    hold_tag;
  logic [OFF_W-1:0]    hold_off;
  logic [NARROW_W-1:0] hold_word;
  logic [TAG_W+OFF_W-1:0] trk_head;

  assign req_ready = !pending && !trk_full;
  assign accept    = req_ready && (req_wr || req_rd);

  cpk_cmd_hold #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .TAG_W(TAG_W), .OFF_W(OFF_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_wr(req_wr), .load_tag(req_tag),
    .load_addr(req_addr), .load_word(req_wdata),
    .cmd_rdy(mem_cmd_rdy), .wdf_rdy(mem_wdf_rdy),
    .pending(pending), .hold_wr(hold_wr), .hold_tag(hold_tag),
    .hold_off(hold_off), .hold_word(hold_word),
    .ui_addr(mem_addr), .ui_en(ui_en), .ui_wren(ui_wren), .rd_fire(rd_fire)
  );

  cpk_lane_packer #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_pack (
    .lane(hold_off), .word(hold_word),
    .wide(mem_wdf_data), .mask(mem_wdf_mask)
  );

  cpk_track_fifo #(.ENT_W(TAG_W + OFF_W), .DEPTH(TRK_DEPTH)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .push(rd_fire), .push_data({hold_tag, hold_off}),
    .pop(trk_pop), .head(trk_head),
    .not_empty(trk_valid), .full(trk_full)
  );

  assign mem_en       = ui_en;
  assign mem_cmd      = hold_wr ? OP_WRITE : OP_READ;
  assign mem_wdf_wren = ui_wren;
  assign mem_wdf_end  = ui_wren;
  assign trk_tag      = trk_head[TAG_W+OFF_W-1:OFF_W];
  assign trk_off      = trk_head[OFF_W-1:0];

  // R2
  wr_both_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wdf_wren |-> (mem_cmd_rdy && mem_wdf_rdy && mem_en && mem_cmd == OP_WRITE));
  // R4
  mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wdf_wren |-> ($countones(mem_wdf_mask) == MASK_W - LANE_B));
  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_wr && !req_rd && !pending) |=> !mem_en);
  // R9
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk_full |-> !req_ready);
endmodule

// File: tb/tb_cpk_top.sv
`timescale 1ns/1ps
module tb_cpk_top;
  localparam int AW = 28, NW = 64, WW = 512, MW = 64, TW = 3, DEPTH = 4;
  localparam int NCYC = 2400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_wr = 0, req_rd = 0, mem_cmd_rdy = 0, mem_wdf_rdy = 0, trk_pop = 0;
  logic [TW-1:0] req_tag = '0;
  logic [AW-1:0] req_addr = '0;
  logic [NW-1:0] req_wdata = '0;
  logic req_ready, mem_en, mem_wdf_wren, mem_wdf_end, trk_valid;
  logic [2:0] mem_cmd, trk_off;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdf_data;
  logic [MW-1:0] mem_wdf_mask;
  logic [TW-1:0] trk_tag;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpk_top #(.TRK_DEPTH(DEPTH)) dut (.*);

  // behavioural reference state
  bit m_busy, m_wr;
  logic [TW-1:0] m_tag;
  logic [AW-1:0] m_addr;
  logic [NW-1:0] m_word;
  logic [TW+2:0] m_q[$];

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_en, e_wren;
    logic [WW-1:0] e_data;
    logic [MW-1:0] e_mask;
    int k;
    e_en   = m_busy && (m_wr ? (mem_cmd_rdy && mem_wdf_rdy) : 1'b1);
    e_wren = m_busy && m_wr && mem_cmd_rdy && mem_wdf_rdy;
    chk(req_ready == (!m_busy && m_q.size() < DEPTH), "R7/R9 req_ready", req_ready, !m_busy && m_q.size() < DEPTH);
    chk(mem_en == e_en, "R2/R5 mem_en", mem_en, e_en);
    chk(mem_wdf_wren == e_wren && mem_wdf_end == e_wren, "R2 wren/end", {mem_wdf_wren, mem_wdf_end}, {e_wren, e_wren});
    if (e_en) begin
      chk(mem_cmd == (m_wr ? 3'd0 : 3'd1), m_wr ? "R2 write code" : "R5 read code", mem_cmd, m_wr ? 0 : 1);
      chk(mem_addr == (m_addr & ~AW'(7)), "R1 aligned addr", mem_addr, m_addr & ~AW'(7));
    end
    if (m_busy && m_wr) begin
      k = int'(m_addr % 8);
      e_data = '0;
      e_data[NW*k +: NW] = m_word;
      for (int b = 0; b < MW; b++) e_mask[b] = (b / 8 != k);
      chk(mem_wdf_data == e_data, "R3 lane data", mem_wdf_data, e_data);
      chk(mem_wdf_mask == e_mask, "R4 byte mask", mem_wdf_mask, e_mask);
    end
    chk(trk_valid == (m_q.size() > 0), "R8 trk_valid", trk_valid, m_q.size() > 0);
    if (m_q.size() > 0)
      chk({trk_tag, trk_off} == m_q[0], "R8 queue head", {trk_tag, trk_off}, m_q[0]);
  endtask

  task automatic advance();
    bit fire, ready;
    ready = !m_busy && m_q.size() < DEPTH;
    fire = m_busy && mem_cmd_rdy && (m_wr ? mem_wdf_rdy : 1'b1);
    if (trk_pop && m_q.size() > 0) void'(m_q.pop_front());
    if (fire) begin
      m_busy = 0;
      if (!m_wr) m_q.push_back({m_tag, m_addr[2:0]});
    end
    if (ready && (req_wr || req_rd)) begin  // R6: no enable, no capture
      m_busy = 1; m_wr = req_wr; m_tag = req_tag; m_addr = req_addr; m_word = req_wdata;
    end
  endtask

  initial begin : watchdog
    repeat (NCYC + 200) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int op, prdy, ppop;
    repeat (3) @(negedge clk);
    #1;
    // R10
    chk(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
    chk(mem_en == 1'b0 && mem_wdf_wren == 1'b0, "R10 reset idle", {mem_en, mem_wdf_wren}, 0);
    chk(trk_valid == 1'b0, "R10 reset queue empty", trk_valid, 0);
    m_busy = 0; m_wr = 0; m_tag = '0; m_addr = '0; m_word = '0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      // phases: free flow, ready stalls, queue filling, idle-heavy
      if (cyc < 500)       begin prdy = 100; ppop = 100; end
      else if (cyc < 1100) begin prdy = 50;  ppop = 60;  end
      else if (cyc < 1700) begin prdy = 85;  ppop = 10;  end
      else                 begin prdy = 70;  ppop = 50;  end
      op = $urandom_range(0, 99);
      req_wr = (op < 35);
      req_rd = (op >= 35 && op < ((cyc >= 1100 && cyc < 1700) ? 90 : 70));
      req_tag = TW'($urandom_range(0, 5));
      req_addr = AW'({$urandom, $urandom});
      req_wdata = {$urandom, $urandom};
      mem_cmd_rdy = ($urandom_range(0, 99) < prdy);
      mem_wdf_rdy = ($urandom_range(0, 99) < prdy);
      trk_pop = ($urandom_range(0, 99) < ppop);
      #1;
      compare();
      advance();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule